// File: doc/BRIEF.md
# Pin Port Register Block

This block is the register side of a 32-pin general-purpose I/O port. A host reaches it through a strobe and write-enable interface with a 4-bit word index, a 32-bit write word and four byte-lane selects. The block holds the pin direction, the output levels and the pull-up and pull-down enables, and drives each of them straight onto the pad-side outputs. The host can also read a synchronized copy of the input pins.

The output-level register can be changed in four ways. A plain load replaces it. Three separate atomic indices set, clear or flip only the bits written as 1. Every kind of write is masked by the byte lanes, so software can drive one group of pins without first reading the register back. All state clears on a synchronous active-high reset. After reset every pin is an input and no pull is enabled.

Top module: `pinport_regs`

## Requirements
- R1: While `rst` is high at a rising clock edge, the direction, output-level, pull-up and pull-down registers clear to zero, and so do `pad_oen`, `pad_out`, `pad_pullup` and `pad_pulldown`.
- R2: Index 0 holds the direction register. It can be read and written, and it drives `pad_oen`. A bit value of 1 makes that pin an output and 0 makes it an input.
- R3: Index 1 holds the output-level register. A write loads it and a read returns it. It drives `pad_out`.
- R4: A write to index 3 ORs the write word into the output-level register.
- R5: A write to index 4 clears each output-level bit whose write-word bit is 1. The register becomes its old value ANDed with the inverted write word.
- R6: A write to index 5 XORs the write word into the output-level register.
- R7: Lane select bit k enables write bits 8k+7 down to 8k. This applies to loads and to the set, clear and toggle writes. A byte whose lane select is 0 keeps its old value.
- R8: A read of index 2 returns `pad_in` through a two-flop synchronizer. A change driven before a clock edge appears in the read data after the second rising edge.
- R9: Index 6 holds the pull-up enable register and index 7 holds the pull-down enable register. Both can be read and written, and they drive `pad_pullup` and `pad_pulldown`.
- R10: Reads of indices 3, 4 and 5, and of any index from 8 to 15, return zero.
- R11: Writes to index 2 and to any index from 8 to 15 change no register.
- R12: `bus_rdata` is combinational. It carries the selected register only while `bus_stb` is high and `bus_wen` is low, and it is zero at all other times.
- R13: A write takes effect at the rising edge where `bus_stb` and `bus_wen` are both high. With `bus_stb` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Access strobe |
| bus_wen | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_lanes | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word |
| pad_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Output levels to the pads |
| pad_oen | output | 32 | Per-pin output enable (direction) |
| pad_pullup | output | 32 | Per-pin pull-up enable |
| pad_pulldown | output | 32 | Per-pin pull-down enable |

## Verification
The hardest case to reach from the ports is an atomic write with only some lanes enabled, applied to an output-level register that already holds a mixed pattern. A plain load cannot tell a set, clear or toggle apart from a load, so the stimulus first loads an irregular pattern. It then runs one full-width write of each atomic kind, followed by a single-lane write of each kind on a different byte. Each result is read back through index 1. Writes to index 2 and to unused indices are followed by reads of the registers they could have corrupted. The synchronizer delay is measured by reading index 2 after exactly one and after exactly two clock edges.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = WORD_W / LANE_W;
    localparam int unsigned IDX_W  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // Register index map seen by the host
    typedef enum logic [IDX_W-1:0] {
        IDX_DIR  = 4'd0,
        IDX_LVL  = 4'd1,
        IDX_PINS = 4'd2,
        IDX_SET  = 4'd3,
        IDX_CLR  = 4'd4,
        IDX_TGL  = 4'd5,
        IDX_PUP  = 4'd6,
        IDX_PDN  = 4'd7
    } reg_idx_e;

    // Operation applied to the output-level register
    typedef enum logic [2:0] {
        LVL_HOLD,
        LVL_LOAD,
        LVL_SET,
        LVL_CLR,
        LVL_TGL
    } lvl_op_e;

    // Decoded host request
    typedef struct packed {
        logic    wr_dir;
        logic    wr_pup;
        logic    wr_pdn;
        lvl_op_e lvl_op;
        word_t   mask;
    } wr_req_t;

    function automatic word_t lvl_next(lvl_op_e op, word_t cur, word_t data, word_t mask);
        word_t eff;
        eff = data & mask;
        case (op)
            LVL_LOAD: lvl_next = (cur & ~mask) | eff;
            LVL_SET:  lvl_next = cur | eff;
            LVL_CLR:  lvl_next = cur & ~eff;
            LVL_TGL:  lvl_next = cur ^ eff;
            default:  lvl_next = cur;
        endcase
    endfunction

endpackage

// File: rtl/pinport_decode.sv
module pinport_decode
    import pinport_pkg::*;
(
    input  logic             stb,
    input  logic             wen,
    input  logic [IDX_W-1:0] addr,
    input  lanes_t           lanes,
    output wr_req_t          req,
    output logic             rd_en,
    output reg_idx_e         idx
);

    word_t mask;
    logic  wr_en;

    // Expand each lane select across its byte
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mask[l*LANE_W +: LANE_W] = {LANE_W{lanes[l]}};
    end

    assign wr_en = stb & wen;
    assign rd_en = stb & ~wen;
    assign idx   = reg_idx_e'(addr);

    always_comb begin
        req        = '0;
        req.lvl_op = LVL_HOLD;
        req.mask   = mask;
        if (wr_en) begin
            case (idx)
                IDX_DIR: req.wr_dir = 1'b1;
                IDX_LVL: req.lvl_op = LVL_LOAD;
                IDX_SET: req.lvl_op = LVL_SET;
                IDX_CLR: req.lvl_op = LVL_CLR;
                IDX_TGL: req.lvl_op = LVL_TGL;
                IDX_PUP: req.wr_pup = 1'b1;
                IDX_PDN: req.wr_pdn = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pinport_cfg_reg.sv
module pinport_cfg_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~mask) | (wdata & mask);
        end
    end

endmodule

// File: rtl/pinport_lvl_reg.sv
module pinport_lvl_reg
    import pinport_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lvl_op_e op,
    input  word_t   mask,
    input  word_t   wdata,
    output word_t   q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (op != LVL_HOLD) begin
            q <= lvl_next(op, q, wdata, mask);
        end
    end

endmodule

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_stb,
    input  logic              bus_wen,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [LANES-1:0]  bus_lanes,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [WORD_W-1:0] pad_in,
    output logic [WORD_W-1:0] pad_out,
    output logic [WORD_W-1:0] pad_oen,
    output logic [WORD_W-1:0] pad_pullup,
    output logic [WORD_W-1:0] pad_pulldown
);

    wr_req_t  req;
    logic     rd_en;
    reg_idx_e idx;
    word_t    dir_q, lvl_q, pup_q, pdn_q, pins_s;

    pinport_decode u_dec (
        .stb   (bus_stb),
        .wen   (bus_wen),
        .addr  (bus_addr),
        .lanes (bus_lanes),
        .req   (req),
        .rd_en (rd_en),
        .idx   (idx)
    );

    pinport_cfg_reg #(.W(WORD_W)) u_dir (
        .clk (clk), .rst (rst), .we (req.wr_dir),
        .mask (req.mask), .wdata (bus_wdata), .q (dir_q)
    );

    pinport_cfg_reg #(.W(WORD_W)) u_pup (
        .clk (clk), .rst (rst), .we (req.wr_pup),
        .mask (req.mask), .wdata (bus_wdata), .q (pup_q)
    );

    pinport_cfg_reg #(.W(WORD_W)) u_pdn (
        .clk (clk), .rst (rst), .we (req.wr_pdn),
        .mask (req.mask), .wdata (bus_wdata), .q (pdn_q)
    );

    pinport_lvl_reg u_lvl (
        .clk (clk), .rst (rst), .op (req.lvl_op),
        .mask (req.mask), .wdata (bus_wdata), .q (lvl_q)
    );

    pinport_sync #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d (pad_in), .q (pins_s)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (idx)
                IDX_DIR:  bus_rdata = dir_q;
                IDX_LVL:  bus_rdata = lvl_q;
                IDX_PINS: bus_rdata = pins_s;
                IDX_PUP:  bus_rdata = pup_q;
                IDX_PDN:  bus_rdata = pdn_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pad_out      = lvl_q;
    assign pad_oen      = dir_q;
    assign pad_pullup   = pup_q;
    assign pad_pulldown = pdn_q;

endmodule

// File: rtl/pinport_regs_checker.sv
module pinport_regs_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_stb,
    input logic        bus_wen,
    input logic [3:0]  bus_addr,
    input logic [3:0]  bus_lanes,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] pad_out,
    input logic [31:0] pad_oen,
    input logic [31:0] pad_pullup,
    input logic [31:0] pad_pulldown
);

    logic wr_full;
    assign wr_full = bus_stb && bus_wen && (bus_lanes == 4'hF);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pad_out == '0 && pad_oen == '0 && pad_pullup == '0 && pad_pulldown == '0));

    a_r2_dir_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_wen && bus_addr == 4'd0) |-> bus_rdata == pad_oen);

    a_r4_set_or: assert property (@(posedge clk) disable iff (rst)
        (wr_full && bus_addr == 4'd3) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

    a_r5_clear_andnot: assert property (@(posedge clk) disable iff (rst)
        (wr_full && bus_addr == 4'd4) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

    a_r6_toggle_xor: assert property (@(posedge clk) disable iff (rst)
        (wr_full && bus_addr == 4'd5) |=> pad_out == ($past(pad_out) ^ $past(bus_wdata)));

    a_r7_no_lane_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_wen && bus_lanes == 4'h0) |=>
        ($stable(pad_out) && $stable(pad_oen) && $stable(pad_pullup) && $stable(pad_pulldown)));

    a_r10_action_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_wen && (bus_addr inside {4'd3, 4'd4, 4'd5} || bus_addr[3]))
        |-> bus_rdata == '0);

    a_r11_ignored_writes: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_wen && (bus_addr == 4'd2 || bus_addr[3])) |=>
        ($stable(pad_out) && $stable(pad_oen) && $stable(pad_pullup) && $stable(pad_pulldown)));

    a_r12_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !(bus_stb && !bus_wen) |-> bus_rdata == '0);

    a_r13_no_strobe_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_stb |=>
        ($stable(pad_out) && $stable(pad_oen) && $stable(pad_pullup) && $stable(pad_pulldown)));

endmodule

bind pinport_regs pinport_regs_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_stb      (bus_stb),
    .bus_wen      (bus_wen),
    .bus_addr     (bus_addr),
    .bus_lanes    (bus_lanes),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_out      (pad_out),
    .pad_oen      (pad_oen),
    .pad_pullup   (pad_pullup),
    .pad_pulldown (pad_pulldown)
);

// File: tb/pinport_regs_test.sv
module pinport_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    // {write idx, lanes, write word, read idx, expected read word}
    localparam logic [75:0] VEC [NV] = '{
        {4'h1, 4'hF, 32'hA5A50F0F, 4'h1, 32'hA5A50F0F},  // R3 load
        {4'h3, 4'hF, 32'h0000F0F0, 4'h1, 32'hA5A5FFFF},  // R4 set
        {4'h4, 4'hF, 32'hA000000F, 4'h1, 32'h05A5FFF0},  // R5 clear
        {4'h5, 4'hF, 32'hFFFF0000, 4'h1, 32'hFA5AFFF0},  // R6 toggle
        {4'h3, 4'h4, 32'hFFFFFFFF, 4'h1, 32'hFAFFFFF0},  // R7 set, lane 2
        {4'h4, 4'h1, 32'hFFFFFFFF, 4'h1, 32'hFAFFFF00},  // R7 clear, lane 0
        {4'h5, 4'h8, 32'hFFFFFFFF, 4'h1, 32'h05FFFF00},  // R7 toggle, lane 3
        {4'h1, 4'h3, 32'h12345678, 4'h1, 32'h05FF5678},  // R7 load, lanes 1:0
        {4'h0, 4'hF, 32'h000000FF, 4'h0, 32'h000000FF},  // R2 direction
        {4'h6, 4'hC, 32'hDEADBEEF, 4'h6, 32'hDEAD0000},  // R9 pull-up
        {4'h7, 4'hF, 32'h00001111, 4'h7, 32'h00001111},  // R9 pull-down
        {4'h2, 4'hF, 32'hFFFFFFFF, 4'h1, 32'h05FF5678},  // R11 input index
        {4'h9, 4'hF, 32'hFFFFFFFF, 4'h0, 32'h000000FF},  // R11 unused
        {4'hF, 4'hF, 32'hFFFFFFFF, 4'h6, 32'hDEAD0000},  // R11 unused
        {4'h1, 4'h0, 32'h00000000, 4'h1, 32'h05FF5678},  // R7 no lanes
        {4'h8, 4'hF, 32'hFFFFFFFF, 4'h3, 32'h00000000},  // R10 set idx
        {4'hA, 4'hF, 32'hFFFFFFFF, 4'h4, 32'h00000000},  // R10 clear idx
        {4'hB, 4'hF, 32'hFFFFFFFF, 4'h5, 32'h00000000},  // R10 toggle idx
        {4'hC, 4'hF, 32'hFFFFFFFF, 4'h8, 32'h00000000},  // R10 unused idx
        {4'hE, 4'hF, 32'hFFFFFFFF, 4'h7, 32'h00001111}   // R11 unused
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stb = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_lanes = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oen, pad_pullup, pad_pulldown;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinport_regs uut (
        .clk          (clk),
        .rst          (rst),
        .bus_stb      (bus_stb),
        .bus_wen      (bus_wen),
        .bus_addr     (bus_addr),
        .bus_lanes    (bus_lanes),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oen      (pad_oen),
        .pad_pullup   (pad_pullup),
        .pad_pulldown (pad_pulldown)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [3:0] l, input logic [31:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_wen = 1'b1; bus_addr = a; bus_lanes = l; bus_wdata = d;
        @(negedge clk);
        bus_stb = 1'b0; bus_wen = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_stb = 1'b1; bus_wen = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the pads and through readback
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oen", pad_oen, 32'h0);
        check("R1 pad_pullup", pad_pullup, 32'h0);
        check("R1 pad_pulldown", pad_pulldown, 32'h0);
        bus_read(4'h1, rd); check("R1 level readback", rd, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][75:72], VEC[i][71:68], VEC[i][67:36]);
            bus_read(VEC[i][35:32], rd);
            check($sformatf("table row %0d", i), rd, VEC[i][31:0]);
        end

        // R2, R3, R9: pad outputs follow the registers
        check("R3 pad_out", pad_out, 32'h05FF5678);
        check("R2 pad_oen", pad_oen, 32'h000000FF);
        check("R9 pad_pullup", pad_pullup, 32'hDEAD0000);
        check("R9 pad_pulldown", pad_pulldown, 32'h00001111);

        // R12: idle and write cycles show zero read data
        @(negedge clk);
        bus_stb = 1'b0; bus_wen = 1'b0; bus_addr = 4'h1;
        #1 check("R12 strobe low", bus_rdata, 32'h0);
        bus_stb = 1'b1; bus_wen = 1'b1; bus_lanes = 4'h0;
        #1 check("R12 write cycle", bus_rdata, 32'h0);
        bus_stb = 1'b0;

        // R13: write-enable without strobe is ignored
        @(negedge clk);
        bus_stb = 1'b0; bus_wen = 1'b1; bus_addr = 4'h1; bus_lanes = 4'hF; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wen = 1'b0;
        check("R13 no strobe pad_out", pad_out, 32'h05FF5678);

        // R8: two-edge synchronizer latency
        @(negedge clk);
        pad_in = 32'h13579BDF;
        @(negedge clk);
        bus_stb = 1'b1; bus_wen = 1'b0; bus_addr = 4'h2;
        #1 check("R8 after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        #1 check("R8 after two edges", bus_rdata, 32'h13579BDF);
        bus_stb = 1'b0;

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rerun pad_out", pad_out, 32'h0);
        check("R1 rerun pad_oen", pad_oen, 32'h0);
        check("R1 rerun pad_pullup", pad_pullup, 32'h0);
        check("R1 rerun pad_pulldown", pad_pulldown, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule